// File: doc/BRIEF.md
# Edge-Timed Entropy Bit Collector

This block turns a single noise line, toggled at random moments by an external analog source, into 32-bit words of raw random data. A counter advances on every clock cycle. Each time the noise line rises, the parity (least significant bit) of that counter is taken as one random bit. Because the rising edges arrive at random times, the parity of the cycle count at each edge is unpredictable, even though the noise line itself is never sampled as data.

The noise line first passes through a synchronizer. Rising edges are then detected and bits are packed into a word. When a full word is ready, it is offered on a valid/ready stream. The producer side cannot be stalled. While a word waits for the consumer, the word and its valid flag hold still, and new edges are dropped rather than queued. That is the whole back-pressure rule: a slow consumer costs entropy, never corrupts a word.

The block also has the following outputs:
- the number of clock cycles between the two most recent rising edges;
- an 8-bit snapshot of the packing register, taken on request;
- a registered copy of the enable input.

Top module: `entropy_edge_collector`

## Requirements
- R1: While `rst_n` is low, `word_valid`, `word_data`, `delta_cycles`, `dbg_snap` and `coll_enabled` are all zero.
- R2: A rising edge of `noise_in` is recognised at the second clock edge after the one that first samples it high, following a sample low. In other words, if samples are low at edge n-1 and high at edge n, the edge is recognised at edge n+2. A falling edge is never recognised.
- R3: On a recognised edge, bit 0 of the cycle counter is shifted into bit 0 of `word_data`, and older bits move one place toward the MSB. The cycle counter holds 0 at the first clock edge after reset and adds 1 at each edge.
- R4: `word_valid` rises at the clock edge that recognises the 32nd bit gathered since reset, the last handshake, or the last cycle with `collect_en` low.
- R5: While `word_valid` is high and `word_ready` is low, `word_valid` and `word_data` keep their values, and recognised edges add no bits.
- R6: A clock edge that sees `word_valid` and `word_ready` both high clears `word_valid` and restarts the bit count from zero.
- R7: While `collect_en` is low, no bits are shifted, `word_valid` goes low at the next edge, and the bit count returns to zero. `coll_enabled` equals `collect_en` delayed by one clock.
- R8: At each recognised edge, `delta_cycles` becomes the cycle-counter value at that edge minus its value at the previous recognised edge. Before any earlier edge, the previous value is taken as 0. This update happens whatever the state of `collect_en` and `word_valid`.
- R9: On a clock edge with `dbg_capture` high, `dbg_snap` takes bits 7..0 of `word_data` as they stood before that edge. Otherwise `dbg_snap` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| noise_in | input | 1 | Noise line from the analog source, asynchronous |
| collect_en | input | 1 | Allows bit gathering when high |
| coll_enabled | output | 1 | `collect_en` registered by one clock |
| word_data | output | 32 | Packed random word |
| word_valid | output | 1 | A full word is on offer |
| word_ready | input | 1 | The consumer takes the word at this edge |
| delta_cycles | output | 32 | Cycles between the two latest rising edges |
| dbg_capture | input | 1 | Strobe that loads the debug snapshot |
| dbg_snap | output | 8 | Low bits of the packing register at the last strobe |

## Verification
The assertions assume that `word_ready` and `collect_en` are ordinary synchronous inputs, and that each `noise_in` level lasts long enough for the synchronizer to see it. A glitch narrower than a clock may legitimately vanish.

The stimulus meets these assumptions. It changes every input at the falling clock edge, and it holds each noise level for two to ten cycles, so every rising edge reaches the detector.

The stimulus also includes the following phases:
- a long stall with ready low, so that edges fall on a held word;
- a phase with ready always high;
- repeated enable drops in the middle of a word.

// File: rtl/eec_pkg.sv
`timescale 1ns/1ps
package eec_pkg;
  localparam int WORD_W_DEF = 32;
  localparam int CNT_W_DEF  = 32;
  localparam int DBG_W_DEF  = 8;
  localparam int SYNC_DEF   = 2;

  typedef enum logic {
    HARV_FILL  = 1'b0,
    HARV_OFFER = 1'b1
  } harv_state_e;
endpackage

// File: rtl/eec_noise_sync.sv
`timescale 1ns/1ps
module eec_noise_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic noise_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= noise_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/eec_free_counter.sv
`timescale 1ns/1ps
module eec_free_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end
endmodule

// File: rtl/eec_interval.sv
`timescale 1ns/1ps
module eec_interval #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] delta
);
  logic [CNT_W-1:0] stamp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      delta   <= '0;
    end else if (rise) begin
      stamp_q <= count;
      delta   <= count - stamp_q;
    end
  end
endmodule

// File: rtl/eec_bit_harvester.sv
`timescale 1ns/1ps
module eec_bit_harvester
  import eec_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              rise,
  input  logic              bit_in,
  input  logic              ready,
  output logic [WORD_W-1:0] data,
  output logic              valid
);
  localparam int BC_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

  harv_state_e     state_q;
  logic [BC_W-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HARV_FILL;
      bits_q  <= '0;
      data    <= '0;
    end else if (!enable) begin
      state_q <= HARV_FILL;
      bits_q  <= '0;
    end else begin
      case (state_q)
        HARV_OFFER: begin
          if (ready) state_q <= HARV_FILL;
        end
        default: begin
          if (rise) begin
            data <= {data[WORD_W-2:0], bit_in};
            if (bits_q == LAST_BIT) begin
              bits_q  <= '0;
              state_q <= HARV_OFFER;
            end else begin
              bits_q <= bits_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign valid = (state_q == HARV_OFFER);
endmodule

// File: rtl/entropy_edge_collector.sv
`timescale 1ns/1ps
module entropy_edge_collector #(
  parameter int WORD_W = eec_pkg::WORD_W_DEF,
  parameter int CNT_W  = eec_pkg::CNT_W_DEF,
  parameter int DBG_W  = eec_pkg::DBG_W_DEF,
  parameter int SYNC_N = eec_pkg::SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              noise_in,
  input  logic              collect_en,
  output logic              coll_enabled,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [CNT_W-1:0]  delta_cycles,
  input  logic              dbg_capture,
  output logic [DBG_W-1:0]  dbg_snap
);
  logic             rise;
  logic [CNT_W-1:0] cycle_cnt;

  eec_noise_sync #(.STAGES(SYNC_N)) i_sync (
    .clk(clk), .rst_n(rst_n), .noise_in(noise_in), .rise_pulse(rise)
  );

  eec_free_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .count(cycle_cnt)
  );

  eec_interval #(.CNT_W(CNT_W)) i_ival (
    .clk(clk), .rst_n(rst_n), .rise(rise), .count(cycle_cnt),
    .delta(delta_cycles)
  );

  eec_bit_harvester #(.WORD_W(WORD_W)) i_harv (
    .clk(clk), .rst_n(rst_n), .enable(collect_en), .rise(rise),
    .bit_in(cycle_cnt[0]), .ready(word_ready),
    .data(word_data), .valid(word_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_enabled <= 1'b0;
      dbg_snap     <= '0;
    end else begin
      coll_enabled <= collect_en;
      if (dbg_capture) dbg_snap <= word_data[DBG_W-1:0];
    end
  end
endmodule

// File: rtl/eec_checker.sv
`timescale 1ns/1ps
module eec_checker #(
  parameter int WORD_W = 32,
  parameter int DBG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              collect_en,
  input logic              coll_enabled,
  input logic [WORD_W-1:0] word_data,
  input logic              word_valid,
  input logic              word_ready,
  input logic              dbg_capture,
  input logic [DBG_W-1:0]  dbg_snap
);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready && collect_en) |=> (word_valid && $stable(word_data)));

  // R6
  handshake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> !word_valid);

  // R7
  disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !collect_en |=> !word_valid);

  // R7
  enable_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collect_en |=> coll_enabled);

  // R4
  offer_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> coll_enabled);

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_capture |=> $stable(dbg_snap));
endmodule

bind entropy_edge_collector eec_checker #(.WORD_W(WORD_W), .DBG_W(DBG_W)) i_eec_chk (
  .clk(clk), .rst_n(rst_n), .collect_en(collect_en), .coll_enabled(coll_enabled),
  .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
  .dbg_capture(dbg_capture), .dbg_snap(dbg_snap)
);

// File: tb/test_entropy_edge_collector.sv
`timescale 1ns/1ps
module test_entropy_edge_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        noise_in = 1'b0;
  logic        collect_en = 1'b0;
  logic        word_ready = 1'b0;
  logic        dbg_capture = 1'b0;
  logic        coll_enabled;
  logic [31:0] word_data;
  logic        word_valid;
  logic [31:0] delta_cycles;
  logic [7:0]  dbg_snap;

  always #4 clk = ~clk;

  entropy_edge_collector i_entropy_edge_collector (
    .clk(clk), .rst_n(rst_n), .noise_in(noise_in), .collect_en(collect_en),
    .coll_enabled(coll_enabled), .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready), .delta_cycles(delta_cycles),
    .dbg_capture(dbg_capture), .dbg_snap(dbg_snap)
  );

  int checks = 0;
  int fails  = 0;
  bit checking = 0;
  bit done = 0;
  int handshakes = 0;
  int rdy_mode = 0;
  int hold = 3;

  // reference model state
  bit          nq[$];
  bit          m_rise;
  longint      m_cnt, m_last;
  logic [31:0] m_data, m_delta;
  logic [7:0]  m_dbg;
  int          m_bits;
  bit          m_valid, m_enabled;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      nq = {1'b0, 1'b0, 1'b0};
      m_cnt = 0; m_last = 0; m_data = '0; m_delta = '0; m_dbg = '0;
      m_bits = 0; m_valid = 0; m_enabled = 0;
    end else begin
      m_rise = nq[$-1] && !nq[$-2];
      nq.push_back(noise_in);
      void'(nq.pop_front());
      if (m_valid && word_ready) handshakes++;
      if (dbg_capture) m_dbg = m_data[7:0];
      m_enabled = collect_en;
      if (m_rise) begin
        m_delta = 32'(m_cnt - m_last);
        m_last  = m_cnt;
      end
      if (!collect_en) begin
        m_valid = 0; m_bits = 0;
      end else if (m_valid) begin
        if (word_ready) m_valid = 0;
      end else if (m_rise) begin
        m_data = {m_data[30:0], m_cnt[0]};
        m_bits++;
        if (m_bits == 32) begin m_valid = 1; m_bits = 0; end
      end
      m_cnt = (m_cnt + 1) & 64'hFFFF_FFFF;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (checking && rst_n) begin
      check("R4 R6 R7 word_valid", {31'b0, word_valid}, {31'b0, m_valid});
      check("R2 R3 R5 word_data", word_data, m_data);
      check("R8 delta_cycles", delta_cycles, m_delta);
      check("R9 dbg_snap", {24'b0, dbg_snap}, {24'b0, m_dbg});
      check("R7 coll_enabled", {31'b0, coll_enabled}, {31'b0, m_enabled});
    end
  end

  // noise, ready and debug strobe drivers
  always @(negedge clk) begin
    if (hold == 0) begin
      noise_in <= ~noise_in;
      hold = $urandom_range(1, 9);
    end else begin
      hold--;
    end
    case (rdy_mode)
      0:       word_ready <= 1'b0;
      1:       word_ready <= 1'b1;
      default: word_ready <= ($urandom_range(0, 3) == 0);
    endcase
    dbg_capture <= ($urandom_range(0, 7) == 0);
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 word_valid", {31'b0, word_valid}, 32'd0);
    check("R1 word_data", word_data, 32'd0);
    check("R1 delta_cycles", delta_cycles, 32'd0);
    check("R1 dbg_snap", {24'b0, dbg_snap}, 32'd0);
    check("R1 coll_enabled", {31'b0, coll_enabled}, 32'd0);
    rst_n = 1'b1;
    checking = 1;
    collect_en = 1'b1;
    rdy_mode = 2;
    repeat (3000) @(negedge clk);
    // R5 long stall
    rdy_mode = 0;
    repeat (1500) @(negedge clk);
    check("R5 word held during stall", {31'b0, word_valid}, 32'd1);
    rdy_mode = 1;
    repeat (1500) @(negedge clk);
    // R7 enable drops mid-word
    for (int i = 0; i < 6; i++) begin
      collect_en = 1'b0;
      repeat (20 + 7 * i) @(negedge clk);
      collect_en = 1'b1;
      repeat (150 + 31 * i) @(negedge clk);
    end
    rdy_mode = 2;
    repeat (2500) @(negedge clk);
    // R6 words were delivered
    checks++;
    if (handshakes < 5) begin
      fails++;
      $display("FAIL R6 handshakes: actual %0d expected at least 5", handshakes);
    end
    done = 1;
    checking = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule